// File: doc/BRIEF.md
# Indexed Serial ADC Result Capture

This block collects one conversion result from an analog-to-digital converter that sends its data serially, most significant bit first, under a bit clock driven by the converter. The block does not use a shift register. A small down-counting index chooses the holding bit that the next serial bit is written into. The index moves on each falling edge of the bit clock. The data line is sampled on the rising edge that follows.

The serial clock and data are brought into the master clock domain through two-flop synchronizers, and both edges are detected there. For this to work, the master clock must run at least four times faster than the serial clock. A one-cycle start strobe re-arms the capture. It presets the index, clears the done flag and forgets any half-seen clock cycle. After the last bit has been stored, the result stays on the output and later serial clock activity is ignored until the next start strobe.

Top module: `adc_word_capture`

## Requirements
- R1: While rst_ni is low, word_o is all zeros and done_o is 0.
- R2: After a start strobe, the first stored serial bit lands in word_o[WORD_W-1]. Each later bit lands one position lower, so bit k of the stream (counting from 0) goes to position WORD_W-1-k.
- R3: The bit stored is the sdat_i level present when sclk_i goes from low to high. Changes on sdat_i while sclk_i stays high do not alter the stored word.
- R4: done_o is 0 until the WORD_W-th bit since the last start strobe has been stored, and is 1 from then on.
- R5: While done_o is 1 and no start strobe arrives, further sclk_i pulses change neither word_o nor done_o.
- R6: A start strobe clears done_o on the next cycle, and done_o falls only after a start strobe. Bits stored before the strobe stay on word_o until they are overwritten.
- R7: A rising sclk_i edge with no falling edge seen since the last start strobe stores nothing. Only a full low-then-high clock cycle writes a bit.
- R8: word_o changes in at most one bit position per master clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial bit clock from the converter; idles high |
| sdat_i | input | 1 | Serial data; valid on the rising edge of sclk_i |
| start_i | input | 1 | One-cycle start-conversion strobe that re-arms the capture |
| word_o | output | WORD_W | Captured conversion result |
| done_o | output | 1 | High once all WORD_W bits are stored |

## Verification
The assertions check on every cycle that the word changes by at most one bit, that the word and flag are frozen once capture is complete, and that the done flag rises and falls only in the correct relation to the start strobe. Only the bench scenarios can show where each bit lands and which data level is taken. These include full random words, partially captured frames that leave older bits in place, data that toggles while the clock is high, and a start strobe issued while the serial clock is low.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  localparam int unsigned WORD_W_DEF = 16;

  typedef struct packed {
    logic rise;
    logic fall;
  } sclk_edge_t;
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int unsigned      W       = 1,
  parameter logic [W-1:0]     RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/sclk_edge_det.sv
module sclk_edge_det
  import adc_cap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  output sclk_edge_t edge_o
);
  // idle level is high, so reset prev high: no false fall out of reset
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign edge_o.rise = lvl_i & ~prev_q;
  assign edge_o.fall = ~lvl_i & prev_q;
endmodule

// File: rtl/bit_index_ctrl.sv
module bit_index_ctrl
  import adc_cap_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  sclk_edge_t       edge_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_pos_o,
  output logic             done_o
);
  // one guard bit so the index can step below zero after the last fall
  localparam logic [IDX_W:0] PRESET = (IDX_W+1)'(WORD_W - 1);
  localparam logic [IDX_W:0] ONE    = (IDX_W+1)'(1);

  logic [IDX_W:0] idx_q;
  logic [IDX_W:0] sel;
  logic           pend_q;
  logic           done_q;
  logic           step;

  assign sel      = idx_q + ONE;  // index points one below the selected bit
  assign wr_pos_o = sel[IDX_W-1:0];
  assign step     = edge_i.fall & ~pend_q & ~done_q & ~start_i;
  assign wr_en_o  = edge_i.rise & pend_q & ~done_q & ~start_i;
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= PRESET;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      idx_q  <= PRESET;
      pend_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (step) begin
        idx_q  <= idx_q - ONE;
        pend_q <= 1'b1;
      end
      if (wr_en_o) begin
        pend_q <= 1'b0;
        if (wr_pos_o == '0) done_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/word_hold.sv
module word_hold #(
  parameter int unsigned WORD_W = 16,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  pos_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    logic hit;
    assign hit = wr_en_i && (pos_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  word_o[i] <= 1'b0;
      else if (hit) word_o[i] <= bit_i;
    end
  end
endmodule

// File: rtl/adc_word_capture.sv
module adc_word_capture
  import adc_cap_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  localparam int unsigned IDX_W = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdat_i,
  input  logic              start_i,
  output logic [WORD_W-1:0] word_o,
  output logic              done_o
);
  logic [1:0]       raw, synced;
  sclk_edge_t       sclk_edge;
  logic             wr_en;
  logic [IDX_W-1:0] wr_pos;

  assign raw = {sclk_i, sdat_i};

  // clock and data share one pipeline so they stay aligned
  sync_2ff #(.W(2), .RST_VAL(2'b10)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (synced)
  );

  sclk_edge_det u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (synced[1]),
    .edge_o (sclk_edge)
  );

  bit_index_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .edge_i   (sclk_edge),
    .wr_en_o  (wr_en),
    .wr_pos_o (wr_pos),
    .done_o   (done_o)
  );

  word_hold #(.WORD_W(WORD_W)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .pos_i   (wr_pos),
    .bit_i   (synced[0]),
    .word_o  (word_o)
  );
endmodule

// File: rtl/adc_word_capture_chk.sv
module adc_word_capture_chk #(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [WORD_W-1:0] word_o,
  input logic              done_o
);
  a_r5_frozen_after_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> ($stable(word_o) && done_o));

  a_r8_one_bit_per_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(word_o ^ $past(word_o)) <= 1);

  a_r6_start_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);

  a_r6_done_falls_on_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> $past(start_i));

  a_r4_done_not_from_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> !$past(start_i));
endmodule

bind adc_word_capture adc_word_capture_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .word_o  (word_o),
  .done_o  (done_o)
);

// File: tb/adc_word_capture_test.sv
module adc_word_capture_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sclk = 1'b1;
  logic         sdat = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] word;
  logic         done;

  int vectors = 0;
  int fails = 0;
  int cyc = 0;

  // reference model state
  logic [W-1:0] m_word = '0;
  int           m_cnt = 0;
  logic         m_pend = 1'b0;
  logic         m_done = 1'b0;

  always #5 clk = ~clk;

  adc_word_capture #(.WORD_W(W)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk),
    .sdat_i  (sdat),
    .start_i (start),
    .word_o  (word),
    .done_o  (done)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL timeout: actual cycles %0d expected < 150000", cyc);
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] place_bit(input logic [W-1:0] w, input int k, input logic b);
    logic [W-1:0] r = w;
    r[W-1-k] = b;
    return r;
  endfunction

  task automatic pulse_start();
    start = 1'b1;
    tick(1);
    start = 1'b0;
    m_cnt = 0; m_pend = 1'b0; m_done = 1'b0;
  endtask

  // one full serial clock cycle; data toggles while high to probe R3
  task automatic send_bit(input logic b);
    sclk = 1'b0;
    if (!m_done) m_pend = 1'b1;
    tick(3);
    sdat = b;
    tick(1);
    sclk = 1'b1;
    tick(1);
    sdat = ~b;
    tick(3);
    if (m_pend && !m_done) begin
      m_word = place_bit(m_word, m_cnt, b);
      m_cnt++;
      m_pend = 1'b0;
      m_done = (m_cnt == W);
    end
  endtask

  task automatic send_word(input logic [W-1:0] v, input int nbits);
    for (int k = 0; k < nbits; k++) send_bit(v[W-1-k]);
  endtask

  initial begin
    logic [W-1:0] v;
    void'($urandom(32'h1d0c_5eed));
    tick(2);
    check("R1 word in reset", 32'(word), 32'(0));
    check("R1 done in reset", 32'(done), 32'(0));
    rst_ni = 1'b1;
    tick(2);

    // directed: single one walks from MSB
    pulse_start();
    send_word(16'h8000, W);
    check("R2 msb first", 32'(word), 32'h8000);
    check("R4 done after full word", 32'(done), 32'(1));

    // partial frame keeps older bits below the new ones (R2, R6)
    pulse_start();
    check("R6 start clears done", 32'(done), 32'(0));
    send_word(16'h5a00, 5);
    check("R2 partial frame word", 32'(word), 32'(m_word));
    check("R4 no done on partial", 32'(done), 32'(0));

    // start issued while sclk low: following rise writes nothing (R7)
    sclk = 1'b0;
    tick(3);
    pulse_start();
    sdat = ~m_word[W-1];
    tick(1);
    sclk = 1'b1;
    tick(4);
    check("R7 lone rise ignored word", 32'(word), 32'(m_word));
    check("R7 lone rise ignored done", 32'(done), 32'(0));
    v = 16'hc3a5;
    send_word(v, W - 1);
    check("R4 no done at bit 15", 32'(done), 32'(0));
    send_bit(v[0]);
    check("R3 sampled at rise", 32'(word), 32'(v));
    check("R4 done at bit 16", 32'(done), 32'(1));

    // extra pulses after done (R5)
    for (int k = 0; k < 3; k++) send_bit(1'($urandom));
    check("R5 word held after done", 32'(word), 32'(v));
    check("R5 done held", 32'(done), 32'(1));

    // random frames
    for (int f = 0; f < 24; f++) begin
      v = W'($urandom);
      pulse_start();
      check("R6 start clears done", 32'(done), 32'(0));
      send_word(v, W);
      check("R2 random word", 32'(word), 32'(m_word));
      check("R4 random done", 32'(done), 32'(1));
      if (f % 4 == 0) begin
        send_bit(1'($urandom));
        check("R5 random extra pulse", 32'(word), 32'(v));
      end
    end

    check("R8 final word", 32'(word), 32'(m_word));
    finish_run();
  end
endmodule